// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 16-bit Static RAM

This block connects a synchronous host to an external asynchronous static RAM of 256K words by 16 bits. The host presents one request at a time. A request carries an address, write data, a direction flag and one enable bit for each byte lane. The controller then drives the memory's active-low strobes, the address bus and the shared data bus. All nanosecond limits are turned into whole clock cycles from a clock-period parameter. Each limit is rounded up to a whole number of periods, and one guard cycle is added.

A read holds chip enable and output enable low for a fixed window and samples the bus on the last clock edge of that window. A write holds write enable low for a minimum pulse. The data is driven for the whole pulse, and a short recovery phase follows while data stays on the bus. Each 8-bit lane has its own enable pin. When a request changes direction from the previous access, the bus gets a turnaround gap with the chip deselected. A request with no lane enabled finishes at once and does not touch the memory. Every transaction ends with a single-cycle ready pulse.

With the default 8 ns clock the timings are as follows. A read window is 8 cycles. A write-enable pulse is 6 cycles, followed by 2 recovery cycles. A turnaround gap is 4 cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, all memory strobes (chip, output, write, both lane enables) are high, rsp_ready is low and rsp_rdata is zero.
- R2: A read keeps chip enable and output enable low and write enable high for exactly RD_CYC consecutive cycles (8 at 8 ns). rsp_rdata takes the bus value sampled on the last edge of that window.
- R3: A write keeps write enable low for exactly WP_CYC consecutive cycles (6 at 8 ns), with output enable high. Chip enable is low for WC_CYC cycles in total (8 at 8 ns). The write data is on the bus during every cycle of the pulse and is still driven when write enable rises.
- R4: Mask bit 0 selects the low-byte enable pin (data bits 7:0), and mask bit 1 selects the high-byte enable pin (data bits 15:8). Only selected lanes are written. A deselected lane reads back as zero in rsp_rdata.
- R5: The controller drives the data bus only in the write-enable and recovery phases, and never while output enable is low.
- R6: When an access goes the other way from the previous completed access, chip enable stays high for at least TURN_CYC cycles (4 at 8 ns) before the new access, which adds TURN_CYC cycles to its latency. From an idle controller, reads and writes both return ready 9 negative edges after the request is presented.
- R7: rsp_ready is high for exactly one cycle at the end of each transaction.
- R8: A request whose lane mask is 00 completes with a ready pulse, never asserts chip enable and leaves memory contents unchanged.
- R9: The address and both lane enables stay constant while chip enable is low.
- R10: Whenever chip enable is high, output enable, write enable and both lane enables are also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data, masked lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low-byte enable, active low |
| mem_ub_n | output | 1 | High-byte enable, active low |
| mem_dq | inout | 16 | Shared tri-state data bus |

## Verification
The memory model in the bench returns valid read data only after the full read window has passed. It commits a write only if the write-enable pulse was long enough. This makes a shortened read window or a shortened write pulse show up as wrong data, not only as a wrong count. The vectors mix full-word, low-only and high-only masks, and they include the lowest, highest and a mid-range address, so a swapped lane pin or a dropped address bit gives a wrong read-back. Direction changes alternate with same-direction runs, which separates a missing turnaround gap from an unconditional one through the measured latency. A zero-mask request followed by a read-back shows that the no-op leaves memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_WREC,
        ST_DONE
    } phase_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } xfer_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // whole periods covering a limit, plus one guard cycle
    function automatic int guarded_cycles(input int limit_ns, input int period_ns);
        return ceil_div(limit_ns, period_ns) + 1;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 8,
    parameter int WP_CYC   = 6,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 4,
    parameter int CNT_W    = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  xfer_t  req_in,
    output phase_t phase,
    output xfer_t  cur,
    output logic   capture,
    output logic   rsp_ready
);

    phase_t           nxt;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             have_last;
    logic             last_write;

    sram_ctrl_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        unique case (phase)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_in.lanes == '0) begin
                        nxt = ST_DONE;
                    end else if (have_last && (last_write != req_in.write)) begin
                        nxt      = ST_TURN;
                        load     = 1'b1;
                        load_val = CNT_W'(TURN_CYC - 1);
                    end else if (req_in.write) begin
                        nxt      = ST_WRITE;
                        load     = 1'b1;
                        load_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        nxt      = ST_READ;
                        load     = 1'b1;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                if (expired) begin
                    load = 1'b1;
                    if (cur.write) begin
                        nxt      = ST_WRITE;
                        load_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        nxt      = ST_READ;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (expired) nxt = ST_DONE;
            end
            ST_WRITE: begin
                if (expired) begin
                    nxt      = ST_WREC;
                    load     = 1'b1;
                    load_val = CNT_W'(WR_CYC - 1);
                end
            end
            ST_WREC: begin
                if (expired) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign capture = (phase == ST_READ) && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            cur        <= '0;
            have_last  <= 1'b0;
            last_write <= 1'b0;
            rsp_ready  <= 1'b0;
        end else begin
            phase     <= nxt;
            rsp_ready <= (nxt == ST_DONE);
            if ((phase == ST_IDLE) && req_valid) begin
                cur <= req_in;
            end
            if ((phase == ST_READ) && expired) begin
                have_last  <= 1'b1;
                last_write <= 1'b0;
            end
            if ((phase == ST_WREC) && expired) begin
                have_last  <= 1'b1;
                last_write <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes
    import sram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [LANES-1:0]  sel,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = ~(active & sel[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            for (int g = 0; g < LANES; g++) begin
                rdata[g*LANE_W +: LANE_W] <= sel[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_BE_NS       = 55,
    parameter int T_WC_NS       = 55,
    parameter int T_WP_NS       = 40,
    parameter int T_DW_NS       = 25,
    parameter int T_HZ_NS       = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_CYC   = guarded_cycles(max_int(T_RC_NS, max_int(T_AA_NS, T_BE_NS)),
                                             CLK_PERIOD_NS);
    localparam int WP_CYC   = max_int(guarded_cycles(T_WP_NS, CLK_PERIOD_NS),
                                      guarded_cycles(T_DW_NS, CLK_PERIOD_NS));
    localparam int WC_CYC   = guarded_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int WR_CYC   = max_int(1, WC_CYC - WP_CYC);
    localparam int TURN_CYC = guarded_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int LONGEST  = max_int(max_int(RD_CYC, WP_CYC), max_int(WR_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    xfer_t              req_in;
    xfer_t              cur;
    phase_t             phase;
    logic               capture;
    logic               active;
    logic               dq_oe;
    logic [DATA_W-1:0]  dq_out;
    logic [LANES-1:0]   lane_n;

    assign req_in = '{write: req_write, addr: req_addr, wdata: req_wdata, lanes: req_lanes};

    sram_ctrl_seq #(
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .WR_CYC  (WR_CYC),
        .TURN_CYC(TURN_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_in   (req_in),
        .phase    (phase),
        .cur      (cur),
        .capture  (capture),
        .rsp_ready(rsp_ready)
    );

    assign active = (phase == ST_READ) || (phase == ST_WRITE) || (phase == ST_WREC);
    assign dq_oe  = (phase == ST_WRITE) || (phase == ST_WREC);
    assign dq_out = cur.wdata;

    sram_ctrl_lanes u_lanes (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .sel    (cur.lanes),
        .capture(capture),
        .dq_in  (mem_dq),
        .lane_n (lane_n),
        .rdata  (rsp_rdata)
    );

    assign mem_addr = cur.addr;
    assign mem_ce_n = ~active;
    assign mem_oe_n = ~(phase == ST_READ);
    assign mem_we_n = ~(phase == ST_WRITE);
    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[LANES-1];
    assign mem_dq   = dq_oe ? dq_out : 'z;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              lb_n,
    input logic              ub_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic              rsp_ready
);

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe); // R5

    AST_WE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n); // R3

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (oe_n && dq_oe)); // R3

    AST_WE_RISE_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> dq_oe); // R3

    AST_READY_ONE: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> $stable(addr)); // R9

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> ($stable(lb_n) && $stable(ub_n))); // R9

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (oe_n && we_n && lb_n && ub_n)); // R10

    AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> !$past(dq_oe)); // R6

endmodule

bind sram_async_ctrl sram_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .lb_n     (mem_lb_n),
    .ub_n     (mem_ub_n),
    .addr     (mem_addr),
    .dq_oe    (dq_oe),
    .rsp_ready(rsp_ready)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

    localparam int PER      = 8;
    localparam int RD_E     = (55 + PER - 1) / PER + 1;   // 8
    localparam int WP_E     = (40 + PER - 1) / PER + 1;   // 6
    localparam int WC_E     = (55 + PER - 1) / PER + 1;   // 8
    localparam int TURN_E   = (20 + PER - 1) / PER + 1;   // 4
    localparam int LAT_E    = 9;

    typedef struct packed {
        logic        wr;
        logic [17:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 18'h00010, 16'hA5C3, 2'b11, 16'h0000},
        '{1'b1, 18'h3FFFF, 16'h1234, 2'b11, 16'h0000},
        '{1'b0, 18'h00010, 16'h0000, 2'b11, 16'hA5C3},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'h1234},
        '{1'b1, 18'h00010, 16'h7E99, 2'b01, 16'h0000},
        '{1'b0, 18'h00010, 16'h0000, 2'b11, 16'hA599},
        '{1'b1, 18'h3FFFF, 16'hBEEF, 2'b10, 16'h0000},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b10, 16'hBE00},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b01, 16'h0034},
        '{1'b1, 18'h20000, 16'h5A5A, 2'b11, 16'h0000},
        '{1'b0, 18'h20000, 16'h0000, 2'b11, 16'h5A5A},
        '{1'b0, 18'h00000, 16'h0000, 2'b11, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_ready;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    wire  [15:0] mem_dq;

    always #4 clk = ~clk;

    sram_async_ctrl u0 (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_lanes(req_lanes),
        .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata),
        .mem_addr (mem_addr),
        .mem_ce_n (mem_ce_n),
        .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n),
        .mem_lb_n (mem_lb_n),
        .mem_ub_n (mem_ub_n),
        .mem_dq   (mem_dq)
    );

    // memory model: data valid only after a full read window, write needs a full pulse
    logic [15:0] mem [int unsigned];
    logic [15:0] rd_word = 16'hEEEE;
    logic [15:0] wr_lat = '0;
    logic        wr_lb = 1'b0, wr_ub = 1'b0;
    int          rd_age = 0, we_age = 0, short_err = 0;
    logic        rd_on;

    assign rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_on && !mem_lb_n) ? rd_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_on && !mem_ub_n) ? rd_word[15:8] : 8'hzz;

    always @(negedge clk) begin
        if (rd_on) begin
            rd_age = rd_age + 1;
            if (rd_age >= RD_E)
                rd_word = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
            else
                rd_word = 16'hEEEE;
        end else begin
            rd_age  = 0;
            rd_word = 16'hEEEE;
        end
        if (!mem_ce_n && !mem_we_n) begin
            we_age = we_age + 1;
            wr_lat = mem_dq;
            wr_lb  = !mem_lb_n;
            wr_ub  = !mem_ub_n;
        end else begin
            if (we_age != 0) begin
                if (we_age >= WP_E) begin
                    logic [15:0] w;
                    w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
                    if (wr_lb) w[7:0]  = wr_lat[7:0];
                    if (wr_ub) w[15:8] = wr_lat[15:8];
                    mem[int'(mem_addr)] = w;
                end else begin
                    short_err = short_err + 1;
                end
            end
            we_age = 0;
        end
    end

    // pin monitor
    int          ce_low = 0, we_low = 0, wd_bad = 0, gap_run = 1000, last_gap = 1000;
    int          hold_bad = 0, desel_bad = 0;
    logic        lb_seen = 1'b0, ub_seen = 1'b0;
    logic [15:0] exp_wd = '0;
    logic        prev_ce_low = 1'b0;
    logic [19:0] prev_pins = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n) begin
                ce_low = ce_low + 1;
                if (!mem_lb_n) lb_seen = 1'b1;
                if (!mem_ub_n) ub_seen = 1'b1;
                if (prev_ce_low && (prev_pins != {mem_addr, mem_lb_n, mem_ub_n}))
                    hold_bad = hold_bad + 1;
                if (!prev_ce_low) last_gap = gap_run;
                gap_run = 0;
            end else begin
                gap_run = gap_run + 1;
                if (!mem_oe_n || !mem_we_n || !mem_lb_n || !mem_ub_n)
                    desel_bad = desel_bad + 1;
            end
            if (!mem_we_n) begin
                we_low = we_low + 1;
                if (mem_dq !== exp_wd) wd_bad = wd_bad + 1;
            end
            prev_ce_low = !mem_ce_n;
            prev_pins   = {mem_addr, mem_lb_n, mem_ub_n};
        end
    end

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic        ready_seen, pulse_ok;
    logic [15:0] got;
    int          lat;

    task automatic run_txn(input logic wr, input logic [17:0] a, input logic [15:0] d,
                           input logic [1:0] be);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_lanes = be; req_valid = 1'b1;
        ce_low = 0; we_low = 0; wd_bad = 0; lb_seen = 1'b0; ub_seen = 1'b0; exp_wd = d;
        lat = 0;
        while (!rsp_ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        ready_seen = rsp_ready;
        got = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        pulse_ok = !rsp_ready;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1", "strobes after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
        chk(!rsp_ready && rsp_rdata == 16'h0, "R1", "ready/rdata after reset",
            {rsp_ready, rsp_rdata}, 0);

        begin
            bit have_prev = 1'b0;
            logic prev_wr = 1'b0;
            for (int i = 0; i < NV; i++) begin
                vec_t v;
                bit turn;
                v = VEC[i];
                turn = have_prev && (prev_wr != v.wr);
                run_txn(v.wr, v.a, v.d, v.be);
                chk(ready_seen, "R7", "ready seen", ready_seen, 1);
                chk(pulse_ok, "R7", "ready one cycle", !pulse_ok, 0);
                chk(lat == LAT_E + (turn ? TURN_E : 0), "R6", "latency", lat,
                    LAT_E + (turn ? TURN_E : 0));
                if (turn) chk(last_gap >= TURN_E, "R6", "turnaround gap", last_gap, TURN_E);
                chk(lb_seen == v.be[0] && ub_seen == v.be[1], "R4", "lane pins",
                    {lb_seen, ub_seen}, {v.be[0], v.be[1]});
                if (v.wr) begin
                    chk(we_low == WP_E, "R3", "we low cycles", we_low, WP_E);
                    chk(ce_low == WC_E, "R3", "ce low cycles", ce_low, WC_E);
                    chk(wd_bad == 0, "R3", "data during pulse", wd_bad, 0);
                end else begin
                    chk(ce_low == RD_E && we_low == 0, "R2", "read window", ce_low, RD_E);
                    chk(got == v.exp, "R2/R4/R5", "read data", got, v.exp);
                end
                have_prev = 1'b1;
                prev_wr = v.wr;
            end
        end

        // zero-mask write must be a no-op
        run_txn(1'b1, 18'h00010, 16'h0000, 2'b00);
        chk(ready_seen && pulse_ok, "R8", "no-op ready", ready_seen, 1);
        chk(ce_low == 0, "R8", "no-op chip enable", ce_low, 0);
        run_txn(1'b0, 18'h00010, 16'h0000, 2'b11);
        chk(got == 16'hA599, "R8", "contents after no-op", got, 16'hA599);

        chk(short_err == 0, "R3", "short write pulses", short_err, 0);
        chk(hold_bad == 0, "R9", "address/lane changes in access", hold_bad, 0);
        chk(desel_bad == 0, "R10", "strobes while deselected", desel_bad, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R7", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule